// File: doc/BRIEF.md
# Bi-Colour LED Matrix Refresh Engine

This block keeps a passive red/green LED panel of 95 by 16 pixels lit without help from the processor. Each pixel takes one bit for its red LED and one for its green LED, so a frame needs 3040 bits, or 380 bytes. The engine holds the frame in an internal buffer. Software fills that buffer through a plain write port with an address, a data byte and a strobe. The engine then reads the buffer by itself and shifts the contents out to the panel, again and again.

The panel is multiplexed as 8 scan rows. Each row is sent as two groups of 24 bytes, so the buffer is 384 bytes deep and the last four bytes are padding. A pacing tick starts exactly one group. After the second group of a row, the engine pulses a latch output for one bit time and then moves the row-select output to the next row. The shift clock rate, the gap between bytes and the tick rate all come from the system clock frequency through parameters. The defaults give a bit time of about 1.25 us, so a byte takes about 10 us, followed by a gap of about 5 us. The default tick is 1 ms, which gives a full frame refresh of 62.5 Hz.

A one-cycle start-of-frame pulse marks the start of row 0, group 0. Software can use it to time updates to the buffer. A write is accepted on any cycle and never delays the scan.

Top module: `ledmx_refresh`

## Requirements
- R1: After reset, and until the first tick, the outputs `shift_clk`, `shift_dat`, `latch` and `frame_start` are 0 and `row_sel` is 0.
- R2: Every byte leaves MSB first. `shift_dat` is set up while `shift_clk` is low and holds steady while `shift_clk` is high. Group g (g = 2*row + half, numbered 0 to 15) sends buffer bytes g*24 to g*24+23 in rising address order.
- R3: Exactly one group of 24 bytes is sent per tick. The first rising edge of `shift_clk` in consecutive groups is exactly TICK cycles apart (CLK_HZ/TICK_HZ).
- R4: Each high phase of `shift_clk` lasts HALF = CLK_HZ/(2*SHIFT_HZ) cycles. Between the last bit of one byte and the first bit of the next byte in the same group, `shift_clk` stays low for at least GAP + HALF cycles, where GAP = CLK_HZ/GAP_HZ.
- R5: After the second group of every row, and only then, `latch` goes high for exactly 2*HALF cycles. That is 48 bytes after the previous latch, and `shift_clk` stays low while `latch` is high.
- R6: `row_sel` holds the current row for all 48 bytes of that row. It steps to (row+1) mod 8 in the same cycle that `latch` falls, so 7 wraps to 0.
- R7: A write to the buffer while scanning is in progress takes effect in the groups sent after the write and leaves the scan timing unchanged.
- R8: A write to an address of 384 or above has no effect on any stored byte. In particular, it does not alias onto the address 384 below it.
- R9: `frame_start` is a one-cycle pulse. It occurs once per frame, before the first bit of row 0, group 0, and at no other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 9 | Buffer byte address (0 to 383 are valid) |
| wr_data | input | 8 | Byte to store |
| shift_clk | output | 1 | Serial clock to the panel; data is sampled on its rising edge |
| shift_dat | output | 1 | Serial data, MSB first |
| latch | output | 1 | Row latch strobe, one bit time long |
| row_sel | output | 3 | Index of the row being driven |
| frame_start | output | 1 | One-cycle pulse at the start of row 0, group 0 |

## Verification
The hardest case to reach from the ports is a buffer write that lands while a frame is already being scanned. For it to count, the write must change what goes out later in that same frame without shifting the timing by even one cycle. The bench waits for the start-of-frame pulse and then rewrites group 15 straight away. It expects the new bytes 15 ticks later and checks that the spacing between groups stays exact throughout. Writes above the buffer end are aimed at the alias of address 16, so that any address wrap would show up in the very first group sent.

// File: rtl/ledmx_pkg.sv
package ledmx_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_LOAD,
        SQ_SEND,
        SQ_LATCH
    } seq_st_e;

    // Byte serialiser phases
    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_GAP
    } sh_st_e;

endpackage

// File: rtl/ledmx_pacer.sv
module ledmx_pacer #(
    parameter int TICK_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tick;
    } pace_t;

    pace_t q, d;

    always_comb begin
        d = q;
        d.tick = 1'b0;
        if (q.cnt == TW'(TICK_CYC - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;

    a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/ledmx_fbuf.sv
module ledmx_fbuf #(
    parameter int DEPTH = 384,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;
    logic       wr_ok;
    logic       rd_ok;

    assign wr_ok = we_i && (waddr_i < AW'(DEPTH));
    assign rd_ok = raddr_i < AW'(DEPTH);

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        rdata_q <= rd_ok ? mem_q[raddr_i] : 8'h00;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/ledmx_shifter.sv
module ledmx_shifter
    import ledmx_pkg::*;
#(
    parameter int HALF_CYC = 156,
    parameter int GAP_CYC  = 1250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    output logic       sclk_o,
    output logic       sdata_o,
    output logic       done_o
);
    localparam int CMAX = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        sh_st_e        st;
        logic [7:0]    sh;
        logic [2:0]    bitn;
        logic [CW-1:0] cnt;
        logic          done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        case (q.st)
            SH_IDLE: begin
                if (start_i) begin
                    d.st   = SH_LOW;
                    d.sh   = byte_i;
                    d.bitn = '0;
                    d.cnt  = '0;
                end
            end
            SH_LOW: begin
                if (q.cnt == CW'(HALF_CYC - 1)) begin
                    d.st  = SH_HIGH;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SH_HIGH: begin
                if (q.cnt == CW'(HALF_CYC - 1)) begin
                    d.cnt = '0;
                    if (q.bitn == 3'd7) begin
                        d.st = SH_GAP;
                    end else begin
                        d.st   = SH_LOW;
                        d.bitn = q.bitn + 1'b1;
                        d.sh   = {q.sh[6:0], 1'b0};
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SH_GAP: begin
                if (q.cnt == CW'(GAP_CYC - 1)) begin
                    d.st   = SH_IDLE;
                    d.cnt  = '0;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: SH_IDLE, sh: '0, bitn: '0, cnt: '0, done: 1'b0};
        else        q <= d;
    end

    assign sclk_o  = (q.st == SH_HIGH);
    assign sdata_o = ((q.st == SH_LOW) || (q.st == SH_HIGH)) ? q.sh[7] : 1'b0;
    assign done_o  = q.done;

    // R2: data must not move while the panel samples it
    a_r2_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

    // R4: a new byte is only accepted once the previous gap has elapsed
    a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (q.st == SH_IDLE));

endmodule

// File: rtl/ledmx_refresh.sv
module ledmx_refresh
    import ledmx_pkg::*;
#(
    parameter int CLK_HZ   = 250_000_000,
    parameter int SHIFT_HZ = 800_000,
    parameter int GAP_HZ   = 200_000,
    parameter int TICK_HZ  = 1000,
    parameter int ROWS     = 8,
    parameter int GPR      = 2,
    parameter int BPG      = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [8:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       shift_clk,
    output logic       shift_dat,
    output logic       latch,
    output logic [2:0] row_sel,
    output logic       frame_start
);
    localparam int HALF_CYC = CLK_HZ / (2 * SHIFT_HZ);
    localparam int GAP_CYC  = CLK_HZ / GAP_HZ;
    localparam int TICK_CYC = CLK_HZ / TICK_HZ;
    localparam int DEPTH    = ROWS * GPR * BPG;
    localparam int AW       = 9;
    localparam int RW       = 3;
    localparam int GW       = (GPR > 1) ? $clog2(GPR) : 1;
    localparam int IW       = $clog2(BPG);
    localparam int LW       = $clog2(2 * HALF_CYC + 1);

    typedef struct packed {
        seq_st_e       st;
        logic [RW-1:0] row;
        logic [GW-1:0] grp;
        logic [IW-1:0] idx;
        logic [LW-1:0] lcnt;
        logic          sof;
    } seq_t;

    seq_t q, d;

    logic          tick;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          sh_start;
    logic          sh_done;
    logic          sclk_w;
    logic          sdat_w;

    ledmx_pacer #(.TICK_CYC(TICK_CYC)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ledmx_fbuf #(.DEPTH(DEPTH), .AW(AW)) u_fbuf (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wdata_i (wr_data),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    ledmx_shifter #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .byte_i  (rd_data),
        .sclk_o  (sclk_w),
        .sdata_o (sdat_w),
        .done_o  (sh_done)
    );

    // Buffer location of the byte being fetched
    always_comb begin
        rd_addr = AW'((32'(q.row) * GPR + 32'(q.grp)) * BPG + 32'(q.idx));
    end

    always_comb begin
        d = q;
        d.sof = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (tick) begin
                    d.st  = SQ_FETCH;
                    d.idx = '0;
                    d.sof = (q.row == '0) && (q.grp == '0);
                end
            end
            SQ_FETCH: d.st = SQ_LOAD;
            SQ_LOAD:  d.st = SQ_SEND;
            SQ_SEND: begin
                if (sh_done) begin
                    if (q.idx == IW'(BPG - 1)) begin
                        d.idx = '0;
                        if (q.grp == GW'(GPR - 1)) begin
                            d.st   = SQ_LATCH;
                            d.lcnt = '0;
                        end else begin
                            d.st  = SQ_IDLE;
                            d.grp = q.grp + 1'b1;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = SQ_FETCH;
                    end
                end
            end
            SQ_LATCH: begin
                if (q.lcnt == LW'(2 * HALF_CYC - 1)) begin
                    d.st   = SQ_IDLE;
                    d.lcnt = '0;
                    d.grp  = '0;
                    d.row  = (q.row == RW'(ROWS - 1)) ? '0 : q.row + 1'b1;
                end else begin
                    d.lcnt = q.lcnt + 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: SQ_IDLE, row: '0, grp: '0, idx: '0, lcnt: '0, sof: 1'b0};
        else        q <= d;
    end

    assign sh_start    = (q.st == SQ_LOAD);
    assign shift_clk   = sclk_w;
    assign shift_dat   = sdat_w;
    assign latch       = (q.st == SQ_LATCH);
    assign row_sel     = q.row;
    assign frame_start = q.sof;

    // R3: a group plus its latch must fit inside one tick period
    a_r3_tick_finds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (q.st == SQ_IDLE));

    // R5: serial clock is quiet while the row latch is asserted
    a_r5_clock_quiet_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !shift_clk);

    // R6: row advances by one (with wrap) as the latch ends
    a_r6_row_steps_on_latch_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch) |-> (row_sel == (($past(row_sel) == RW'(ROWS - 1)) ? '0 : $past(row_sel) + 1'b1)));

    // R9: frame marker lasts one cycle and only at row 0
    a_r9_sof_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    a_r9_sof_on_row0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (row_sel == '0));

endmodule

// File: tb/ledmx_refresh_test.sv
module ledmx_refresh_test;

    localparam int CLK_HZ   = 250_000_000;
    localparam int SHIFT_HZ = 62_500_000;
    localparam int GAP_HZ   = 62_500_000;
    localparam int TICK_HZ  = 200_000;
    localparam int HALF     = CLK_HZ / (2 * SHIFT_HZ);
    localparam int GAP      = CLK_HZ / GAP_HZ;
    localparam int TICK     = CLK_HZ / TICK_HZ;
    localparam int NBYTES   = 384;
    localparam int FRAMES   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       shift_clk, shift_dat, latch, frame_start;
    logic [2:0] row_sel;

    always #2 clk = ~clk;

    ledmx_refresh #(
        .CLK_HZ(CLK_HZ), .SHIFT_HZ(SHIFT_HZ), .GAP_HZ(GAP_HZ), .TICK_HZ(TICK_HZ)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .shift_clk(shift_clk), .shift_dat(shift_dat), .latch(latch),
        .row_sel(row_sel), .frame_start(frame_start)
    );

    typedef struct {
        logic [7:0] val;
        int         addr;
        int         row;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] model [NBYTES];
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done_flag = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 9'(a);
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Driver: load the buffer, queue the expected stream, disturb it mid-frame
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check({shift_clk, shift_dat, latch, frame_start} == 4'b0, "R1", "outputs after reset",
              int'({shift_clk, shift_dat, latch, frame_start}), 0);
        check(row_sel == 3'd0, "R1", "row after reset", int'(row_sel), 0);
        for (int a = 0; a < NBYTES; a++) begin
            model[a] = 8'(a * 37 + 11);
            wr(a, model[a]);
        end
        // R8: out-of-range writes, one aliasing address 16
        wr(400, 8'h5A);
        wr(511, 8'hA5);
        check({shift_clk, latch, frame_start} == 3'b0, "R1", "outputs before first tick",
              int'({shift_clk, latch, frame_start}), 0);
        // R7: new group 15 contents written once frame 0 has begun
        for (int a = 360; a < NBYTES; a++) model[a] = 8'(~(a * 5));
        for (int f = 0; f < FRAMES; f++)
            for (int a = 0; a < NBYTES; a++)
                exp_q.push_back('{val: model[a], addr: a, row: a / 48});
        @(posedge frame_start);
        for (int a = 360; a < NBYTES; a++) wr(a, model[a]);
        wait (exp_q.size() == 0);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R3", "queue drained", exp_q.size(), 0);
        finish_run();
    end

    // Monitor
    int  bitcnt = 0;
    int  byte_ctr = 0;
    int  since_latch = 0;
    int  high_run = 0;
    int  low_run = 0;
    int  latch_run = 0;
    int  cyc = 0;
    int  last_grp_cyc = -1;
    int  lat_row = 0;
    bit  prev_sclk = 1'b0;
    bit  prev_latch = 1'b0;
    bit  sof_seen = 1'b0;
    logic [7:0] shreg = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (frame_start) begin
                // R9: only one pulse per group start
                check(!sof_seen, "R9", "frame_start repeated", 1, 0);
                sof_seen = 1'b1;
            end
            if (shift_clk && !prev_sclk) begin
                if (bitcnt == 0) begin
                    if (byte_ctr % 24 == 0) begin
                        // R3: group starts exactly one tick apart
                        if (last_grp_cyc >= 0)
                            check(cyc - last_grp_cyc == TICK, "R3", "group spacing",
                                  cyc - last_grp_cyc, TICK);
                        last_grp_cyc = cyc;
                        // R9: marker only ahead of group 0
                        check(sof_seen == ((byte_ctr / 24) % 16 == 0), "R9", "frame_start at group",
                              int'(sof_seen), int'((byte_ctr / 24) % 16 == 0));
                        sof_seen = 1'b0;
                    end else begin
                        // R4: inter-byte gap
                        check(low_run >= GAP + HALF, "R4", "inter-byte low time", low_run, GAP + HALF);
                    end
                end
                shreg = {shreg[6:0], shift_dat};
                bitcnt++;
                if (bitcnt == 8) begin
                    bitcnt = 0;
                    byte_ctr++;
                    since_latch++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3", "unexpected extra byte", int'(shreg), -1);
                    end else begin
                        exp_t e;
                        string tag;
                        e = exp_q.pop_front();
                        tag = (e.addr == 16) ? "R8" : ((e.addr >= 360) ? "R7" : "R2");
                        check(shreg == e.val, tag, $sformatf("byte @%0d", e.addr), int'(shreg), int'(e.val));
                        check(int'(row_sel) == e.row % 8, "R6", "row during byte", int'(row_sel), e.row % 8);
                    end
                end
                low_run = 0;
            end
            if (!shift_clk && prev_sclk) begin
                // R4: high phase length
                check(high_run == HALF, "R4", "clock high width", high_run, HALF);
                high_run = 0;
            end
            if (shift_clk) high_run++;
            else           low_run++;
            if (latch && !prev_latch) begin
                // R5: latch after 48 bytes, on the current row
                check(since_latch == 48, "R5", "bytes before latch", since_latch, 48);
                check(int'(row_sel) == lat_row, "R6", "row at latch", int'(row_sel), lat_row);
                check(bitcnt == 0, "R5", "latch mid-byte", bitcnt, 0);
                since_latch = 0;
                latch_run = 0;
            end
            if (latch) latch_run++;
            if (!latch && prev_latch) begin
                check(latch_run == 2 * HALF, "R5", "latch width", latch_run, 2 * HALF);
                lat_row = (lat_row + 1) % 8;
                check(int'(row_sel) == lat_row, "R6", "row after latch", int'(row_sel), lat_row);
            end
            prev_sclk  = shift_clk;
            prev_latch = latch;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", exp_q.size(), 0);
        finish_run();
    end

endmodule